// File: doc/BRIEF.md
# Configurable Byte SPI Master

This block is a byte-wide SPI master. A 16-bit configuration register sets the clock polarity and phase, the bit order and the event that starts a transfer. It also sets how the block handles a full receive holding register and an empty transmit holding register. Each transfer shifts one byte out on `mosi` and samples one byte from `miso`, framed by the active-low `cs_n`. The serial clock runs at a fixed fraction of the system clock, set by the `HALF_DIV` parameter.

Software talks to the block through strobes. `tx_we` loads the transmit holding register, `rx_re` marks a read of the receive holding register and `stat_re` marks a read of the sticky overflow flag. The block can start a transfer in one of two ways: when a byte is written, or when the previous result is read. The `irq` output follows whichever condition matches the chosen start event. In continuous framing, chip select stays low across bytes for as long as transmit data is waiting. In single framing, every byte gets its own chip-select window, and consecutive windows are separated by an idle gap.

Top module: `spi_byte_master`

## Requirements
- R1: Control bits 15:13 and bit 4 always read as zero. Transfers run only while bit 0 (enable) and bit 1 (master) are both set. Otherwise `cs_n` stays high, `irq` is low and a written byte stays pending.
- R2: Bit 3 gives the `sclk` level whenever `cs_n` is high. With bit 2 clear, each bit's clock pulse falls in the second half of the bit. With bit 2 set, the pulse falls in the first half. In both cases `miso` is sampled at the middle of the bit.
- R3: With bit 5 set, the least significant bit is shifted first in both directions. With bit 5 clear, the most significant bit is shifted first.
- R4: With bit 6 set, a write to the transmit register starts a transfer, and `irq` is high while the block is running and the transmit register is empty. With bit 6 clear, only a receive read starts a transfer, and `irq` equals the receive-full flag.
- R5: With bit 12 set, a byte waiting in the transmit register when the current byte ends is sent straight after it, with `cs_n` held low.
- R6: With bit 12 clear, each byte has its own `cs_n` low window. Consecutive windows are separated by at least two `sclk` periods, and by at most one such gap plus two system clocks.
- R7: With bit 11 set, the receive shifter takes the block's own `mosi` bits and `miso` has no effect.
- R8: When a byte completes while the receive register is full, the old data is kept if bit 8 is clear and replaced if bit 8 is set.
- R9: `ovf_flag` sets whenever a byte completes into a full receive register, under either setting of bit 8. It stays set until a `stat_re` strobe.
- R10: A transfer started with the transmit register empty sends 0x00 if bit 7 is set. If bit 7 is clear, it resends the last byte that was sent.
- R11: Clearing bit 0 during a transfer drives `cs_n` high and `sclk` to its idle level from the clock edge that writes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Configuration write strobe |
| ctrl_wdata | input | 16 | Configuration write data |
| ctrl_rdata | output | 16 | Configuration readback, reserved bits zero |
| tx_we | input | 1 | Transmit register write strobe |
| tx_wdata | input | DATA_W | Transmit byte |
| tx_full | output | 1 | Transmit register holds an unsent byte |
| rx_re | input | 1 | Receive register read strobe |
| rx_rdata | output | DATA_W | Receive register contents |
| rx_full | output | 1 | Receive register holds unread data |
| stat_re | input | 1 | Status read strobe, clears the overflow flag |
| ovf_flag | output | 1 | Sticky receive overflow flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong bit counter or shift state shows up within the same byte. The slave model then sees a number of clock pulses that is not a multiple of eight per chip-select window, or decodes a byte that differs from the one queued. A faulty holding-register flag shows up at the next completed byte: `rx_rdata`, `ovf_flag` or `irq` disagrees with the expected result of the write and read strobes. Framing faults show in the count of chip-select windows and in the measured gap length once the second byte of a pair starts.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

   localparam logic [15:0] CTRL_MASK = 16'h1FEF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic cont;
      logic loop;
      logic ovwr;
      logic und_zero;
      logic tx_trig;
      logic lsb_first;
      logic cpol;
      logic cpha;
      logic master;
      logic en;
   } spi_cfg_t;

   function automatic spi_cfg_t decode_ctrl(input logic [15:0] r);
      spi_cfg_t c;
      c.en        = r[0];
      c.master    = r[1];
      c.cpha      = r[2];
      c.cpol      = r[3];
      c.lsb_first = r[5];
      c.tx_trig   = r[6];
      c.und_zero  = r[7];
      c.ovwr      = r[8];
      c.loop      = r[11];
      c.cont      = r[12];
      return c;
   endfunction

endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
   import spi_master_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [15:0] wdata,
   output logic [15:0] ctrl_q,
   output spi_cfg_t    cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (we) ctrl_q <= wdata & CTRL_MASK;
   end

   assign cfg = decode_ctrl(ctrl_q);

endmodule

// File: rtl/spi_buffers.sv
module spi_buffers #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tx_trig,
   input  logic              und_zero,
   input  logic              ovwr,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_re,
   input  logic              stat_re,
   input  logic              take,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              go,
   output logic              tx_avail,
   output logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_q,
   output logic              rx_full,
   output logic              tx_full,
   output logic              ovf,
   output logic              irq
);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] last_tx;
   logic              start_pend;

   assign go       = tx_trig ? tx_full : start_pend;
   assign tx_avail = tx_full;
   assign tx_byte  = tx_full  ? tx_q :
                     und_zero ? '0   : last_tx;
   assign irq      = active && (tx_trig ? !tx_full : rx_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q       <= '0;
         tx_full    <= 1'b0;
         last_tx    <= '0;
         start_pend <= 1'b0;
      end else begin
         if (take) begin
            tx_full    <= 1'b0;
            last_tx    <= tx_byte;
            start_pend <= 1'b0;
         end
         if (tx_we) begin
            tx_q    <= tx_wdata;
            tx_full <= 1'b1;
         end
         if (tx_trig || !active) start_pend <= 1'b0;
         else if (rx_re)         start_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rx_full <= 1'b0;
         ovf     <= 1'b0;
      end else begin
         if (rx_re)   rx_full <= 1'b0;
         if (stat_re) ovf     <= 1'b0;
         if (done) begin
            if (!rx_full) begin
               rx_q    <= rx_byte;
               rx_full <= 1'b1;
            end else begin
               ovf <= 1'b1;
               if (ovwr) rx_q <= rx_byte;
            end
         end
      end
   end

   // R9: the overflow flag is sticky until a status read
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !stat_re) |=> ovf);

   // R8: discard policy leaves unread receive data untouched
   p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_re && !ovwr) |=> $stable(rx_q));

   // R4: in write-triggered mode the engine only consumes real data
   p_take_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && tx_trig) |-> tx_full);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_master_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int HALF_DIV   = 2,
   parameter int GAP_HALVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              loopback,
   input  logic              cont,
   input  logic              go,
   input  logic              tx_avail,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              miso,
   output logic              take,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);

   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int BIT_W = $clog2(DATA_W);
   localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
   localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_HALVES - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (GAP_HALVES < 1) begin : g_bad_gap
      $error("GAP_HALVES must be at least 1");
   end

   eng_state_t        state;
   logic              half;
   logic [BIT_W-1:0]  bitc;
   logic [GAP_W-1:0]  gap_cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] rsh;
   logic [DATA_W-1:0] tx_rev;
   logic [DATA_W-1:0] rx_rev;
   logic [DATA_W-1:0] tx_ord;
   logic              tick;
   logic              running;
   logic              in_xfer;
   logic              end_byte;
   logic              chain;
   logic              din;

   assign running = active && (state != ST_IDLE);

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [CNT_W-1:0] div_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                div_cnt <= '0;
         else if (!running || tick) div_cnt <= '0;
         else                       div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == CNT_W'(HALF_DIV - 1));
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign tx_rev[i] = tx_byte[DATA_W-1-i];
      assign rx_rev[i] = rsh[DATA_W-1-i];
   end

   assign tx_ord   = lsb_first ? tx_rev : tx_byte;
   assign rx_byte  = lsb_first ? rx_rev : rsh;
   assign in_xfer  = active && (state == ST_XFER);
   assign end_byte = in_xfer && tick && half && (bitc == LAST_BIT);
   assign chain    = end_byte && cont && tx_avail;
   assign done     = end_byte;
   assign take     = (active && (state == ST_IDLE) && go) || chain;

   assign mosi = in_xfer ? sh[DATA_W-1] : 1'b0;
   assign din  = loopback ? mosi : miso;
   assign cs_n = !in_xfer;
   assign sclk = cpol ^ (in_xfer && (half != cpha));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         half    <= 1'b0;
         bitc    <= '0;
         gap_cnt <= '0;
         sh      <= '0;
         rsh     <= '0;
      end else if (!active) begin
         state   <= ST_IDLE;
         half    <= 1'b0;
         bitc    <= '0;
         gap_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state <= ST_XFER;
                  half  <= 1'b0;
                  bitc  <= '0;
                  sh    <= tx_ord;
               end
            end
            ST_XFER: begin
               if (tick) begin
                  if (!half) begin
                     rsh  <= {rsh[DATA_W-2:0], din};
                     half <= 1'b1;
                  end else begin
                     half <= 1'b0;
                     if (bitc == LAST_BIT) begin
                        bitc <= '0;
                        if (cont && tx_avail) begin
                           sh <= tx_ord;
                        end else begin
                           state   <= ST_GAP;
                           gap_cnt <= '0;
                        end
                     end else begin
                        bitc <= bitc + 1'b1;
                        sh   <= {sh[DATA_W-2:0], 1'b0};
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt == LAST_GAP) state <= ST_IDLE;
                  else                     gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: the bit counter is parked at zero outside a byte
   p_bitc_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_XFER) |-> (bitc == '0));

   // R6: chip select is high for the whole inter-frame gap
   p_gap_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> cs_n);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_master_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int HALF_DIV   = 2,
   parameter int GAP_HALVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [15:0]       ctrl_wdata,
   output logic [15:0]       ctrl_rdata,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_full,
   input  logic              rx_re,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_full,
   input  logic              stat_re,
   output logic              ovf_flag,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);

   spi_cfg_t          cfg;
   logic              active;
   logic              go;
   logic              tx_avail;
   logic [DATA_W-1:0] tx_byte;
   logic              take;
   logic              done;
   logic [DATA_W-1:0] rx_byte;

   spi_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (ctrl_wdata),
      .ctrl_q (ctrl_rdata),
      .cfg    (cfg)
   );

   assign active = cfg.en && cfg.master;

   spi_buffers #(.DATA_W(DATA_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .tx_trig  (cfg.tx_trig),
      .und_zero (cfg.und_zero),
      .ovwr     (cfg.ovwr),
      .tx_we    (tx_we),
      .tx_wdata (tx_wdata),
      .rx_re    (rx_re),
      .stat_re  (stat_re),
      .take     (take),
      .done     (done),
      .rx_byte  (rx_byte),
      .go       (go),
      .tx_avail (tx_avail),
      .tx_byte  (tx_byte),
      .rx_q     (rx_rdata),
      .rx_full  (rx_full),
      .tx_full  (tx_full),
      .ovf      (ovf_flag),
      .irq      (irq)
   );

   spi_shift_engine #(
      .DATA_W     (DATA_W),
      .HALF_DIV   (HALF_DIV),
      .GAP_HALVES (GAP_HALVES)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cpol      (cfg.cpol),
      .cpha      (cfg.cpha),
      .lsb_first (cfg.lsb_first),
      .loopback  (cfg.loop),
      .cont      (cfg.cont),
      .go        (go),
      .tx_avail  (tx_avail),
      .tx_byte   (tx_byte),
      .miso      (miso),
      .take      (take),
      .done      (done),
      .rx_byte   (rx_byte),
      .sclk      (sclk),
      .mosi      (mosi),
      .cs_n      (cs_n)
   );

   // R2: the serial clock rests at the polarity level outside a frame
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == cfg.cpol));

   // R11: losing enable closes the frame at once
   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(active)) |-> cs_n);

   // R1: no interrupt while the block is not running as master
   p_irq_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !irq);

endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_DIV   = 2;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [15:0]   ctrl_wdata = '0;
   logic [15:0]   ctrl_rdata;
   logic          tx_we = 1'b0;
   logic [DW-1:0] tx_wdata = '0;
   logic          tx_full;
   logic          rx_re = 1'b0;
   logic [DW-1:0] rx_rdata;
   logic          rx_full;
   logic          stat_re = 1'b0;
   logic          ovf_flag;
   logic          irq;
   logic          sclk;
   logic          mosi;
   logic          miso = 1'b0;
   logic          cs_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_byte_master #(.DATA_W(DW), .HALF_DIV(HALF_DIV), .GAP_HALVES(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata),
      .tx_full(tx_full), .rx_re(rx_re), .rx_rdata(rx_rdata),
      .rx_full(rx_full), .stat_re(stat_re), .ovf_flag(ovf_flag), .irq(irq),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   typedef struct {
      logic [7:0] mo;
      logic [7:0] mi;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   int   frames   = 0;
   logic mon_en   = 1'b1;
   logic cpol_tb  = 1'b0;
   logic cpha_tb  = 1'b0;
   logic lsb_tb   = 1'b0;
   logic prev_sclk = 1'b0;
   logic prev_cs   = 1'b1;
   int   nb = 0;
   logic [7:0] mo_acc = '0;
   logic [7:0] cur_mi = '0;
   logic       done_flag = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic mi_bit(input int idx);
      return lsb_tb ? cur_mi[idx] : cur_mi[7-idx];
   endfunction

   // Scoreboard monitor: slave model decoding mosi and driving miso
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (prev_cs && !cs_n) begin
            nb = 0;
            cur_mi = (q.size() != 0) ? q[0].mi : 8'h00;
            miso = mi_bit(0);
         end
         if (!cs_n && (prev_sclk != sclk) && (sclk == (cpol_tb ^ !cpha_tb))) begin
            if (lsb_tb) mo_acc[nb] = mosi;
            else        mo_acc[7-nb] = mosi;
            nb++;
            if (nb == 8) begin
               nb = 0;
               if (q.size() == 0) begin
                  chk("R3 unexpected byte on mosi", {24'd0, mo_acc}, 32'hFFFF_FFFF);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk("R3 mosi byte", {24'd0, mo_acc}, {24'd0, e.mo});
               end
               cur_mi = (q.size() != 0) ? q[0].mi : 8'h00;
               miso = mi_bit(0);
            end else begin
               miso = mi_bit(nb);
            end
         end
         if (!prev_cs && cs_n) begin
            frames++;
            chk("R2 whole bytes per cs window", nb, 0);
         end
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
   end

   task automatic wr_ctrl(input logic [15:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      cpha_tb = v[2]; cpol_tb = v[3]; lsb_tb = v[5];
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wr_tx(input logic [7:0] mo, input logic [7:0] mi);
      exp_t e;
      e.mo = mo; e.mi = mi;
      q.push_back(e);
      @(negedge clk);
      tx_we = 1'b1; tx_wdata = mo;
      @(negedge clk);
      tx_we = 1'b0;
   endtask

   task automatic push_exp(input logic [7:0] mo, input logic [7:0] mi);
      exp_t e;
      e.mo = mo; e.mi = mi;
      q.push_back(e);
   endtask

   task automatic pulse_rx();
      @(negedge clk); rx_re = 1'b1;
      @(negedge clk); rx_re = 1'b0;
   endtask

   task automatic pulse_stat();
      @(negedge clk); stat_re = 1'b1;
      @(negedge clk); stat_re = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (q.size() != 0 || !cs_n);
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog expired before the sequence ended");
         finish_run();
      end
   end

   initial begin
      int f0;
      int gap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 cs_n after reset", cs_n, 1);
      chk("R1 sclk after reset", sclk, 0);
      chk("R1 irq after reset", irq, 0);
      chk("R1 ctrl after reset", ctrl_rdata, 0);

      wr_ctrl(16'hFFFF);
      chk("R1 reserved bits read zero", ctrl_rdata, 32'h1FEF);

      // R1: enable without master bit must not transfer
      wr_ctrl(16'h0041);
      wr_tx(8'h11, 8'h00);
      repeat (40) @(negedge clk);
      chk("R1 no frame without master", frames, 0);
      chk("R1 byte still pending", tx_full, 1);
      wr_ctrl(16'h0043);
      wait_done();
      chk("R1 frame after master set", frames, 1);
      pulse_rx();

      // R4/R2/R3: write-triggered, cpol0 cpha0 msb first
      chk("R4 irq with tx empty", irq, 1);
      wr_tx(8'hA5, 8'h3C);
      chk("R4 irq low with tx full", irq, 0);
      wait_done();
      chk("R2 rx data mode 0", rx_rdata, 32'h3C);
      chk("R2 rx full", rx_full, 1);
      pulse_rx();

      // R2/R3: cpol1 cpha1 lsb first
      wr_ctrl(16'h006F);
      chk("R2 sclk idles high", sclk, 1);
      wr_tx(8'h81, 8'h4E);
      wait_done();
      chk("R3 rx lsb first", rx_rdata, 32'h4E);
      pulse_rx();

      // R2: remaining phase/polarity pairs
      wr_ctrl(16'h004B);
      wr_tx(8'h6D, 8'hB2);
      wait_done();
      chk("R2 rx cpol1 cpha0", rx_rdata, 32'hB2);
      pulse_rx();
      wr_ctrl(16'h0067);
      wr_tx(8'h1E, 8'hC7);
      wait_done();
      chk("R2 rx cpol0 cpha1 lsb", rx_rdata, 32'hC7);
      pulse_rx();

      // R7: loopback ignores miso
      wr_ctrl(16'h0843);
      wr_tx(8'h96, 8'hFF);
      wait_done();
      chk("R7 loopback rx equals tx", rx_rdata, 32'h96);
      pulse_rx();

      // R8/R9: overflow with discard then overwrite
      wr_ctrl(16'h0043);
      wr_tx(8'h12, 8'h21);
      wait_done();
      chk("R9 no overflow yet", ovf_flag, 0);
      wr_tx(8'h34, 8'h43);
      wait_done();
      chk("R8 discard keeps old byte", rx_rdata, 32'h21);
      chk("R9 overflow flag set", ovf_flag, 1);
      pulse_stat();
      chk("R9 status read clears flag", ovf_flag, 0);
      wr_ctrl(16'h0143);
      wr_tx(8'h56, 8'h65);
      wait_done();
      chk("R8 overwrite replaces byte", rx_rdata, 32'h65);
      chk("R9 overflow under overwrite", ovf_flag, 1);
      pulse_stat();
      pulse_rx();

      // R5: continuous framing
      wr_ctrl(16'h1043);
      f0 = frames;
      wr_tx(8'hC3, 8'h01);
      while (tx_full) @(negedge clk);
      wr_tx(8'h3C, 8'h02);
      wait_done();
      chk("R5 one cs window for two bytes", frames - f0, 1);
      chk("R5 first byte kept in rx", rx_rdata, 32'h01);
      pulse_rx();
      pulse_stat();

      // R6: single framing with gap
      wr_ctrl(16'h0043);
      f0 = frames;
      wr_tx(8'hF0, 8'h0A);
      while (tx_full) @(negedge clk);
      wr_tx(8'h0F, 8'h0B);
      do @(negedge clk); while (!cs_n);
      gap = 0;
      while (cs_n) begin
         gap++;
         @(negedge clk);
      end
      chk("R6 gap at least two sclk periods", (gap >= 4*HALF_DIV) ? 1 : 0, 1);
      chk("R6 gap not too long", (gap <= 4*HALF_DIV + 2) ? 1 : 0, 1);
      wait_done();
      chk("R6 two cs windows", frames - f0, 2);
      pulse_rx();
      pulse_stat();

      // R4/R10: read-triggered, underflow policies
      wr_ctrl(16'h0003);
      f0 = frames;
      wr_tx(8'h5A, 8'h77);
      repeat (40) @(negedge clk);
      chk("R4 write does not start in read mode", frames - f0, 0);
      chk("R4 irq low with rx empty", irq, 0);
      pulse_rx();
      wait_done();
      chk("R4 irq follows rx full", irq, 1);
      chk("R4 read-started rx data", rx_rdata, 32'h77);
      push_exp(8'h5A, 8'h88);
      pulse_rx();
      wait_done();
      chk("R10 repeat previous byte rx", rx_rdata, 32'h88);
      wr_ctrl(16'h0083);
      push_exp(8'h00, 8'h99);
      pulse_rx();
      wait_done();
      chk("R10 zero underflow rx", rx_rdata, 32'h99);

      // R11: abort mid transfer
      wr_ctrl(16'h0043);
      mon_en = 1'b0;
      wr_tx(8'hFF, 8'h00);
      do @(negedge clk); while (cs_n);
      repeat (10) @(negedge clk);
      wr_ctrl(16'h0042);
      chk("R11 cs_n high after disable", cs_n, 1);
      chk("R11 sclk idle after disable", sclk, 0);
      repeat (40) @(negedge clk);
      chk("R11 stays idle", cs_n, 1);
      q.delete();

      done_flag = 1'b1;
      finish_run();
   end

endmodule